// File: doc/BRIEF.md
# Nine-bit serial receiver with address-frame filter

This block turns an asynchronous serial line into bytes. It supports two frame shapes. The short frame has one start bit, eight data bits and one stop bit. The long frame adds a ninth bit between the last data bit and the stop bit. The line is oversampled by a free-running baud tick. Each bit is settled by a three-sample majority vote near its middle. A start bit counts only if the line is still low at mid-bit.

When a frame finishes, the received byte and one status bit are loaded into output registers, and a receive interrupt flag is set. In the short frame the status bit holds the stop bit. In the long frame it holds the ninth bit.

A low stop bit sets a framing-error flag. This flag stays set until software strobes it clear. A multiprocessor enable lets a node ignore traffic that is not meant for it. With the enable set, only frames whose status bit comes out as 1 are loaded and raise the interrupt. In the long frame that bit is the ninth bit, which marks an address. In the short frame it is a valid stop bit. Frames that are filtered out leave the byte and status registers untouched.

Top module: `uart9_rx`

## Requirements
- R1: After a synchronous reset, `rx_byte` is 0x00, and `rx_bit9`, `rx_irq` and `rx_ferr` are all 0.
- R2: Data bits are assembled least-significant bit first. The first bit after the start bit becomes `rx_byte[0]`.
- R3: With `frame_nine` = 0 (start, 8 data, stop), an accepted frame loads the sampled stop bit into `rx_bit9`.
- R4: With `frame_nine` = 1 (start, 8 data, ninth bit, stop), an accepted frame loads the ninth bit into `rx_bit9`. The stop bit never reaches `rx_bit9`.
- R5: A stop bit sampled as 0 sets `rx_ferr`, in either frame shape and whether or not the frame is filtered.
- R6: `rx_ferr` is cleared only by `clr_ferr`. A later frame with a valid stop bit leaves it at 1.
- R7: With `addr_only` = 1 and `frame_nine` = 1, a frame sets `rx_irq` only if its ninth bit is 1 (address). A ninth bit of 0 (data) does not set it.
- R8: With `addr_only` = 1 and `frame_nine` = 0, a frame sets `rx_irq` only if its stop bit is 1.
- R9: A frame rejected by the filter leaves `rx_byte` and `rx_bit9` at their previous values.
- R10: A falling edge on `rxd` starts a frame only if `rxd` is still low at the mid-bit vote, OVERSAMPLE/2 ticks later. Otherwise the receiver returns to idle and nothing is loaded.
- R11: Each bit value is the majority of three samples, taken on ticks OVERSAMPLE/2-1, OVERSAMPLE/2 and OVERSAMPLE/2+1 of the bit. A single wrong sample does not change the bit.
- R12: `rx_irq` stays at 1 after it is set until `clr_irq` is strobed. A frame that finishes while it is set keeps it at 1. Setting takes precedence over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| frame_nine | input | 1 | 0: 10-bit frame, 1: 11-bit frame with ninth bit |
| addr_only | input | 1 | Multiprocessor filter enable |
| baud_tick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| clr_irq | input | 1 | Strobe clearing the receive interrupt flag |
| clr_ferr | input | 1 | Strobe clearing the framing-error flag |
| rx_byte | output | DATA_W | Last accepted data byte |
| rx_bit9 | output | 1 | Stop bit (10-bit frame) or ninth bit (11-bit frame) of last accepted frame |
| rx_irq | output | 1 | Receive interrupt flag |
| rx_ferr | output | 1 | Sticky framing-error flag |

## Verification
The bench builds the receiver with OVERSAMPLE = 8, DATA_W = 8 and SYNC_STAGES = 2, and it holds the baud tick high on every cycle. Each bit then lasts exactly eight clocks, and the offset from a line change to each vote sample is fixed. Because of this, a one-clock glitch can be placed on exactly one of the three votes of a chosen bit, and a start pulse can be made just short of the mid-bit check. Short frames also keep the runs for the filter, framing-error and interrupt sequences small.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart9_bit_timer.sv
module uart9_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic din,
  output logic decide,
  output logic bit_end,
  output logic vote
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [CW-1:0] C_FIRST = CW'(MID - 1);
  localparam logic [CW-1:0] C_SECOND = CW'(MID);
  localparam logic [CW-1:0] C_THIRD = CW'(MID + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt;
  logic          samp_a, samp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
      if (cnt == C_FIRST)  samp_a <= din;
      if (cnt == C_SECOND) samp_b <= din;
    end
  end

  assign decide  = tick && !restart && (cnt == C_THIRD);
  assign bit_end = tick && !restart && (cnt == C_LAST);
  assign vote    = (samp_a & samp_b) | (samp_a & din) | (samp_b & din);
endmodule

// File: rtl/uart9_frame.sv
module uart9_frame
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              frame_nine,
  input  logic              addr_only,
  input  logic              clr_irq,
  input  logic              clr_ferr,
  input  logic              decide,
  input  logic              bit_end,
  input  logic              vote,
  output logic              restart,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              rx_irq,
  output logic              rx_ferr
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  rx_state_t         state;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              ninth;
  logic              flag_bit;
  logic              accept;

  assign restart  = (state == ST_IDLE) && tick && !rxd_s;
  assign flag_bit = frame_nine ? ninth : vote;
  assign accept   = !addr_only || flag_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      shreg   <= '0;
      ninth   <= 1'b0;
      rx_byte <= '0;
      rx_bit9 <= 1'b0;
      rx_irq  <= 1'b0;
      rx_ferr <= 1'b0;
    end else begin
      if (clr_irq)  rx_irq  <= 1'b0;
      if (clr_ferr) rx_ferr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (restart) state <= ST_START;
        end
        ST_START: begin
          if (decide && vote) begin
            state <= ST_IDLE;
          end else if (bit_end) begin
            state <= ST_DATA;
            idx   <= '0;
          end
        end
        ST_DATA: begin
          if (decide) shreg <= {vote, shreg[DATA_W-1:1]};
          if (bit_end) begin
            if (idx == LAST_IDX) state <= frame_nine ? ST_NINTH : ST_STOP;
            else                 idx   <= idx + 1'b1;
          end
        end
        ST_NINTH: begin
          if (decide)  ninth <= vote;
          if (bit_end) state <= ST_STOP;
        end
        ST_STOP: begin
          if (decide) begin
            if (!vote) rx_ferr <= 1'b1;
            if (accept) begin
              rx_byte <= shreg;
              rx_bit9 <= flag_bit;
              rx_irq  <= 1'b1;
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ferr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_ferr && !clr_ferr) |=> rx_ferr);

  assert_ferr_at_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ferr) |-> ($past(state) == ST_STOP));

  assert_addr_filter_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> (!$past(addr_only) || !$past(frame_nine) || rx_bit9));

  assert_hold_outside_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_STOP) |=> ($stable(rx_byte) && $stable(rx_bit9)));

  assert_start_abort_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && decide && vote) |=> (state == ST_IDLE));

  assert_irq_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && !clr_irq) |=> rx_irq);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              frame_nine,
  input  logic              addr_only,
  input  logic              baud_tick,
  input  logic              clr_irq,
  input  logic              clr_ferr,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              rx_irq,
  output logic              rx_ferr
);
  logic rxd_s;
  logic restart, decide, bit_end, vote;

  uart9_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  uart9_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick   (baud_tick),
    .restart(restart),
    .din    (rxd_s),
    .decide (decide),
    .bit_end(bit_end),
    .vote   (vote)
  );

  uart9_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .rxd_s     (rxd_s),
    .frame_nine(frame_nine),
    .addr_only (addr_only),
    .clr_irq   (clr_irq),
    .clr_ferr  (clr_ferr),
    .decide    (decide),
    .bit_end   (bit_end),
    .vote      (vote),
    .restart   (restart),
    .rx_byte   (rx_byte),
    .rx_bit9   (rx_bit9),
    .rx_irq    (rx_irq),
    .rx_ferr   (rx_ferr)
  );
endmodule

// File: tb/uart9_rx_bench.sv
module uart9_rx_bench;
  localparam int OVS = 8;
  localparam int DW  = 8;

  typedef struct {
    logic [DW-1:0] byte_v;
    logic          bit9;
    logic          irq;
    logic          ferr;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic frame_nine = 1'b0;
  logic addr_only = 1'b0;
  logic baud_tick = 1'b1;
  logic clr_irq = 1'b0;
  logic clr_ferr = 1'b0;
  logic [DW-1:0] rx_byte;
  logic rx_bit9, rx_irq, rx_ferr;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  logic [DW-1:0] m_byte = '0;
  logic m_bit9 = 1'b0, m_irq = 1'b0, m_ferr = 1'b0;

  always #5 clk = ~clk;

  uart9_rx #(.OVERSAMPLE(OVS), .DATA_W(DW), .SYNC_STAGES(2)) u_uart9_rx (
    .clk(clk), .rst(rst), .rxd(rxd), .frame_nine(frame_nine),
    .addr_only(addr_only), .baud_tick(baud_tick), .clr_irq(clr_irq),
    .clr_ferr(clr_ferr), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .rx_irq(rx_irq), .rx_ferr(rx_ferr)
  );

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "rx_byte", rx_byte, e.byte_v);
      cmp(e.tag, "rx_bit9", DW'(rx_bit9), DW'(e.bit9));
      cmp(e.tag, "rx_irq", DW'(rx_irq), DW'(e.irq));
      cmp(e.tag, "rx_ferr", DW'(rx_ferr), DW'(e.ferr));
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e.byte_v = m_byte; e.bit9 = m_bit9; e.irq = m_irq; e.ferr = m_ferr; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    for (int o = 0; o < OVS; o++) begin
      rxd = (glitch && o == 5) ? ~v : v;
      @(negedge clk);
    end
  endtask

  // glitch_at: frame bit index (0 = start) that gets one flipped sample, -1 for none
  task automatic send_frame(input logic [DW-1:0] d, input logic b9, input logic stop, input int glitch_at);
    logic flag;
    drive_bit(1'b0, glitch_at == 0);
    for (int i = 0; i < DW; i++) drive_bit(d[i], glitch_at == i + 1);
    if (frame_nine) drive_bit(b9, glitch_at == DW + 1);
    drive_bit(stop, 1'b0);
    rxd = 1'b1;
    repeat (2 * OVS) @(negedge clk);
    flag = frame_nine ? b9 : stop;
    if (!stop) m_ferr = 1'b1;
    if (!addr_only || flag) begin
      m_byte = d; m_bit9 = flag; m_irq = 1'b1;
    end
  endtask

  task automatic pulse_clear(input logic ci, input logic cf);
    clr_irq = ci; clr_ferr = cf;
    @(negedge clk);
    clr_irq = 1'b0; clr_ferr = 1'b0;
    if (ci) m_irq = 1'b0;
    if (cf) m_ferr = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_now("R1 reset");

    frame_nine = 1'b0;
    send_frame(8'hA5, 1'b0, 1'b1, -1);
    expect_now("R2 R3 short frame stop into bit9");
    pulse_clear(1'b1, 1'b0);

    frame_nine = 1'b1;
    send_frame(8'h3C, 1'b0, 1'b1, -1);
    expect_now("R4 ninth bit 0 stored");
    pulse_clear(1'b1, 1'b0);

    send_frame(8'h81, 1'b1, 1'b0, -1);
    expect_now("R4 R5 ninth bit 1, bad stop sets ferr");
    pulse_clear(1'b1, 1'b0);

    frame_nine = 1'b0;
    send_frame(8'h5A, 1'b0, 1'b1, -1);
    expect_now("R6 valid stop keeps ferr");
    send_frame(8'h11, 1'b0, 1'b1, -1);
    expect_now("R12 irq held across second frame");
    pulse_clear(1'b0, 1'b1);
    expect_now("R6 clr_ferr clears flag");
    pulse_clear(1'b1, 1'b0);
    expect_now("R12 clr_irq clears flag");

    send_frame(8'h22, 1'b0, 1'b0, -1);
    expect_now("R3 R5 short frame bad stop loaded as 0");
    pulse_clear(1'b1, 1'b1);

    addr_only = 1'b1; frame_nine = 1'b1;
    send_frame(8'h77, 1'b0, 1'b1, -1);
    expect_now("R7 R9 data frame filtered");
    send_frame(8'h42, 1'b1, 1'b1, -1);
    expect_now("R7 address frame accepted");
    pulse_clear(1'b1, 1'b0);

    frame_nine = 1'b0;
    send_frame(8'h99, 1'b0, 1'b0, -1);
    expect_now("R8 R9 R5 short frame bad stop filtered");
    pulse_clear(1'b0, 1'b1);
    send_frame(8'hC3, 1'b0, 1'b1, -1);
    expect_now("R8 short frame valid stop accepted");
    pulse_clear(1'b1, 1'b0);
    addr_only = 1'b0;

    rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    expect_now("R10 short start pulse ignored");
    send_frame(8'h0F, 1'b0, 1'b1, -1);
    expect_now("R10 frame after aborted start");
    pulse_clear(1'b1, 1'b0);

    send_frame(8'hE7, 1'b0, 1'b1, 1);
    expect_now("R11 glitch on bit0 outvoted");
    pulse_clear(1'b1, 1'b0);
    frame_nine = 1'b1;
    send_frame(8'h00, 1'b0, 1'b1, 4);
    expect_now("R11 glitch on bit3 outvoted");
    send_frame(8'h6B, 1'b1, 1'b1, DW + 1);
    expect_now("R11 glitch on ninth bit outvoted");
    pulse_clear(1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule